// File: doc/BRIEF.md
# Block Refill Controller for a Direct-Mapped Cache

This block serves word reads for a direct-mapped cache whose lines hold four words. A word address is accepted on a valid/ready request channel and latched. The latched address is then split into three parts: the word offset within the line, the slot index and the tag. If the addressed slot holds a valid line with the same tag, the offset selects one of the four stored words. That word is returned on a valid/ready response channel.

If the slot does not hold the line, the slot is marked empty and the controller starts a refill from main memory. Main memory has a fixed timing: one cycle to present the line address, then for each of the four words a 15-cycle access followed by a one-cycle transfer. The words are fetched in order from offset 0 to offset 3 and written into the slot. After that, the tag is written and the line becomes valid. The controller raises a one-cycle completion pulse, retries the lookup and returns the word. A cycle counter reports the length of the stall, which is 65 cycles with the default timing.

Back-pressure rules: a request is taken only on a cycle with `req_valid` and `req_ready` both high. `req_ready` stays low from acceptance until the response has been taken. A response, once raised, holds `rsp_valid`, `rsp_data` and `rsp_hit` steady until a cycle with `rsp_ready` high.

Top module: `blk_refill_ctrl`

## Requirements
- R1: A 16-bit word address maps as follows: bits [1:0] give the word within the line, bits [5:2] give the slot index (16 slots), and bits [15:6] give the tag. Two addresses that share bits [5:2] but differ in bits [15:6] compete for the same slot.
- R2: A lookup hits when the slot is valid and its stored tag equals the address tag. A hit returns the stored word selected by bits [1:0], with `rsp_hit`=1, in the second cycle after acceptance. A hit causes no memory activity.
- R3: A refill starts with `mem_addr_valid` high for exactly one cycle, with `mem_addr` pointing at word 0 of the line. Then `mem_take` is high four times, with `mem_addr` at offsets 0, 1, 2 and 3 in that order. `mem_rdata` is captured on each `mem_take` cycle.
- R4: Each `mem_take` comes 16 cycles after the previous address strobe or take: 15 access cycles plus the transfer cycle.
- R5: When `refill_done` is high, `stall_count` equals 65 (1 + 4×16). A missing access delivers its response 69 cycles after acceptance.
- R6: `refill_done` is a single-cycle pulse. It comes after the fourth `mem_take`, once per refill.
- R7: After a refill, the retried lookup returns the requested word from memory with `rsp_hit`=0. Later reads of any word of that line hit.
- R8: A miss on an occupied slot replaces its line. A later access with the old tag misses again.
- R9: `req_ready` is low while a request is in progress. `rsp_valid`, `rsp_data` and `rsp_hit` stay stable while `rsp_ready` is low.
- R10: After reset all slots are empty, `req_ready`=1, and `rsp_valid`, `mem_addr_valid`, `mem_take`, `refill_done` and `stall_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | 16 | Word address of the request |
| rsp_valid | output | 1 | Response word present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 32 | Requested word |
| rsp_hit | output | 1 | 1 if served without a refill |
| mem_addr_valid | output | 1 | One-cycle line address strobe to memory |
| mem_addr | output | 16 | Word address sent to memory |
| mem_take | output | 1 | Transfer cycle: `mem_rdata` is captured |
| mem_rdata | input | 32 | Word returned by memory |
| refill_done | output | 1 | One-cycle pulse when a line refill completes |
| stall_count | output | 8 | Cycles spent in the current or last refill |

## Verification
The assertions assume that main memory honours the fixed timing: `mem_rdata` must already hold the word for `mem_addr` in every `mem_take` cycle. The bench meets this with a memory model that computes each word combinationally from its address. The assertions also assume the consumer may withhold `rsp_ready` for any length of time. The stimulus uses fixed-seed random addresses confined to three tags over all slots, which mixes cold misses, hits and conflict evictions. It holds responses back for random numbers of cycles and changes inputs only on falling edges.

// File: rtl/rfl_pkg.sv
package rfl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_SEND,
    ST_ACCESS,
    ST_XFER,
    ST_UPDATE,
    ST_RESP
  } rfl_state_e;

  // Total refill stall: address cycle plus access and transfer per word
  function automatic int refill_penalty(input int words, input int access_cyc);
    return 1 + words * (access_cyc + 1);
  endfunction

endpackage

// File: rtl/rfl_line_store.sv
module rfl_line_store #(
  parameter int IDX_W     = 4,
  parameter int TAG_W     = 10,
  parameter int WORD_W    = 32,
  parameter int BLK_WORDS = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [IDX_W-1:0]                    slot_idx,
  output logic                                rd_valid,
  output logic [TAG_W-1:0]                    rd_tag,
  output logic [BLK_WORDS-1:0][WORD_W-1:0]    rd_line,
  input  logic                                inv_en,
  input  logic                                wr_en,
  input  logic [$clog2(BLK_WORDS)-1:0]        wr_off,
  input  logic [WORD_W-1:0]                   wr_data,
  input  logic                                fill_en,
  input  logic [TAG_W-1:0]                    fill_tag
);
  localparam int SLOTS = 1 << IDX_W;

  logic [SLOTS-1:0]                 valid_q;
  logic [TAG_W-1:0]                 tag_q  [SLOTS];
  logic [BLK_WORDS-1:0][WORD_W-1:0] data_q [SLOTS];

  // Presence bits: cleared at reset and when a refill starts in the slot
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot_valid
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[s] <= 1'b0;
      end else if (slot_idx == IDX_W'(s)) begin
        if (inv_en)       valid_q[s] <= 1'b0;
        else if (fill_en) valid_q[s] <= 1'b1;
      end
    end
  end

  // Tag and data storage carries no reset; presence bits guard it
  always_ff @(posedge clk) begin
    if (fill_en) tag_q[slot_idx] <= fill_tag;
    if (wr_en)   data_q[slot_idx][wr_off] <= wr_data;
  end

  assign rd_valid = valid_q[slot_idx];
  assign rd_tag   = tag_q[slot_idx];
  assign rd_line  = data_q[slot_idx];

endmodule

// File: rtl/rfl_word_sel.sv
module rfl_word_sel #(
  parameter int WORD_W    = 32,
  parameter int BLK_WORDS = 4
) (
  input  logic [BLK_WORDS-1:0][WORD_W-1:0] line,
  input  logic [$clog2(BLK_WORDS)-1:0]     off,
  output logic [WORD_W-1:0]                word
);
  localparam int OFF_W = $clog2(BLK_WORDS);

  logic [BLK_WORDS-1:0][WORD_W-1:0] gated;

  // AND-OR multiplexer, one leg per word of the line
  for (genvar w = 0; w < BLK_WORDS; w++) begin : g_leg
    assign gated[w] = (off == OFF_W'(w)) ? line[w] : '0;
  end

  always_comb begin
    word = '0;
    for (int w = 0; w < BLK_WORDS; w++) word = word | gated[w];
  end

endmodule

// File: rtl/rfl_fsm.sv
module rfl_fsm
  import rfl_pkg::*;
#(
  parameter int BLK_WORDS  = 4,
  parameter int ACCESS_CYC = 15,
  parameter int STALL_W    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic                         lookup_hit,
  input  logic                         rsp_ready,
  output logic                         req_ready,
  output logic                         accept,
  output logic                         load_rsp,
  output logic                         rsp_valid,
  output logic                         first_try,
  output logic                         inv_en,
  output logic                         wr_en,
  output logic                         fill_en,
  output logic [$clog2(BLK_WORDS)-1:0] word_idx,
  output logic                         mem_addr_valid,
  output logic                         mem_take,
  output logic                         refill_done,
  output logic [STALL_W-1:0]           stall_count
);
  localparam int OFF_W = $clog2(BLK_WORDS);
  localparam int ACC_W = $clog2(ACCESS_CYC + 1);

  rfl_state_e         state_q, state_d;
  logic [ACC_W-1:0]   acc_q;
  logic [OFF_W-1:0]   widx_q;
  logic [STALL_W-1:0] stall_q;
  logic               first_q;

  wire last_access = (acc_q == ACC_W'(ACCESS_CYC - 1));
  wire last_word   = (widx_q == OFF_W'(BLK_WORDS - 1));
  wire in_refill   = (state_q == ST_SEND) || (state_q == ST_ACCESS) || (state_q == ST_XFER);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid) state_d = ST_LOOKUP;
      ST_LOOKUP: state_d = lookup_hit ? ST_RESP : ST_SEND;
      ST_SEND:   state_d = ST_ACCESS;
      ST_ACCESS: if (last_access) state_d = ST_XFER;
      ST_XFER:   state_d = last_word ? ST_UPDATE : ST_ACCESS;
      ST_UPDATE: state_d = ST_LOOKUP;
      ST_RESP:   if (rsp_ready) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      acc_q   <= '0;
      widx_q  <= '0;
      stall_q <= '0;
      first_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid) first_q <= 1'b1;
      if (state_q == ST_LOOKUP && !lookup_hit) begin
        first_q <= 1'b0;
        stall_q <= '0;
        widx_q  <= '0;
      end
      if (in_refill) stall_q <= stall_q + 1'b1;
      if (state_q == ST_SEND) acc_q <= '0;
      if (state_q == ST_ACCESS) acc_q <= acc_q + 1'b1;
      if (state_q == ST_XFER) begin
        acc_q <= '0;
        if (!last_word) widx_q <= widx_q + 1'b1;
      end
    end
  end

  assign req_ready      = (state_q == ST_IDLE);
  assign accept         = (state_q == ST_IDLE) && req_valid;
  assign load_rsp       = (state_q == ST_LOOKUP) && lookup_hit;
  assign rsp_valid      = (state_q == ST_RESP);
  assign first_try      = first_q;
  assign inv_en         = (state_q == ST_LOOKUP) && !lookup_hit;
  assign wr_en          = (state_q == ST_XFER);
  assign fill_en        = (state_q == ST_UPDATE);
  assign word_idx       = widx_q;
  assign mem_addr_valid = (state_q == ST_SEND);
  assign mem_take       = (state_q == ST_XFER);
  assign refill_done    = (state_q == ST_UPDATE);
  assign stall_count    = stall_q;

endmodule

// File: rtl/blk_refill_ctrl.sv
module blk_refill_ctrl #(
  parameter int ADDR_W     = 16,
  parameter int WORD_W     = 32,
  parameter int IDX_W      = 4,
  parameter int BLK_WORDS  = 4,
  parameter int ACCESS_CYC = 15,
  parameter int STALL_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_data,
  output logic              rsp_hit,
  output logic              mem_addr_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_take,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              refill_done,
  output logic [STALL_W-1:0] stall_count
);
  localparam int OFF_W = $clog2(BLK_WORDS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] rsp_q;

  wire [OFF_W-1:0] a_off = addr_q[OFF_W-1:0];
  wire [IDX_W-1:0] a_idx = addr_q[OFF_W +: IDX_W];
  wire [TAG_W-1:0] a_tag = addr_q[ADDR_W-1 -: TAG_W];

  logic                             accept, load_rsp, inv_en, wr_en, fill_en;
  logic                             rd_valid, lookup_hit;
  logic [TAG_W-1:0]                 rd_tag;
  logic [BLK_WORDS-1:0][WORD_W-1:0] rd_line;
  logic [WORD_W-1:0]                sel_word;
  logic [OFF_W-1:0]                 word_idx;

  assign lookup_hit = rd_valid && (rd_tag == a_tag);

  rfl_fsm #(
    .BLK_WORDS (BLK_WORDS),
    .ACCESS_CYC(ACCESS_CYC),
    .STALL_W   (STALL_W)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .lookup_hit    (lookup_hit),
    .rsp_ready     (rsp_ready),
    .req_ready     (req_ready),
    .accept        (accept),
    .load_rsp      (load_rsp),
    .rsp_valid     (rsp_valid),
    .first_try     (rsp_hit),
    .inv_en        (inv_en),
    .wr_en         (wr_en),
    .fill_en       (fill_en),
    .word_idx      (word_idx),
    .mem_addr_valid(mem_addr_valid),
    .mem_take      (mem_take),
    .refill_done   (refill_done),
    .stall_count   (stall_count)
  );

  rfl_line_store #(
    .IDX_W    (IDX_W),
    .TAG_W    (TAG_W),
    .WORD_W   (WORD_W),
    .BLK_WORDS(BLK_WORDS)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .slot_idx(a_idx),
    .rd_valid(rd_valid),
    .rd_tag  (rd_tag),
    .rd_line (rd_line),
    .inv_en  (inv_en),
    .wr_en   (wr_en),
    .wr_off  (word_idx),
    .wr_data (mem_rdata),
    .fill_en (fill_en),
    .fill_tag(a_tag)
  );

  rfl_word_sel #(
    .WORD_W   (WORD_W),
    .BLK_WORDS(BLK_WORDS)
  ) u_sel (
    .line(rd_line),
    .off (a_off),
    .word(sel_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rsp_q  <= '0;
    end else begin
      if (accept)   addr_q <= req_addr;
      if (load_rsp) rsp_q  <= sel_word;
    end
  end

  assign rsp_data = rsp_q;
  assign mem_addr = {a_tag, a_idx, word_idx};

endmodule

// File: rtl/blk_refill_ctrl_chk.sv
module blk_refill_ctrl_chk #(
  parameter int ADDR_W     = 16,
  parameter int WORD_W     = 32,
  parameter int BLK_WORDS  = 4,
  parameter int ACCESS_CYC = 15,
  parameter int STALL_W    = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [WORD_W-1:0]  rsp_data,
  input logic               rsp_hit,
  input logic               mem_addr_valid,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic               mem_take,
  input logic               refill_done,
  input logic [STALL_W-1:0] stall_count
);
  localparam int OFF_W   = $clog2(BLK_WORDS);
  localparam int PENALTY = rfl_pkg::refill_penalty(BLK_WORDS, ACCESS_CYC);
  localparam int GAP_W   = $clog2(ACCESS_CYC + 3);
  localparam int GAP_MAX = (1 << GAP_W) - 1;

  logic [GAP_W-1:0] gap_q;
  logic [OFF_W:0]   takes_q;

  // Cycles since the last address strobe or transfer, and transfers seen
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q   <= '0;
      takes_q <= '0;
    end else begin
      if (mem_addr_valid || mem_take) gap_q <= GAP_W'(1);
      else if (gap_q != GAP_W'(GAP_MAX)) gap_q <= gap_q + 1'b1;
      if (mem_addr_valid) takes_q <= '0;
      else if (mem_take) takes_q <= takes_q + 1'b1;
    end
  end

  p_busy_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_hit)));

  p_strobe_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr_valid |=> (!mem_addr_valid && !mem_take));

  p_strobe_word0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr_valid |-> (mem_addr[OFF_W-1:0] == '0));

  p_word_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_take |-> (mem_addr[OFF_W-1:0] == takes_q[OFF_W-1:0] && takes_q < (OFF_W+1)'(BLK_WORDS)));

  p_word_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_take |-> (gap_q == GAP_W'(ACCESS_CYC + 1)));

  p_penalty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    refill_done |-> (stall_count == STALL_W'(PENALTY)));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    refill_done |=> !refill_done);

  p_done_after_words_r6: assert property (@(posedge clk) disable iff (!rst_n)
    refill_done |-> (takes_q == (OFF_W+1)'(BLK_WORDS)));

  p_no_mem_while_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!mem_addr_valid && !mem_take && !refill_done));

endmodule

bind blk_refill_ctrl blk_refill_ctrl_chk #(
  .ADDR_W    (ADDR_W),
  .WORD_W    (WORD_W),
  .BLK_WORDS (BLK_WORDS),
  .ACCESS_CYC(ACCESS_CYC),
  .STALL_W   (STALL_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_data      (rsp_data),
  .rsp_hit       (rsp_hit),
  .mem_addr_valid(mem_addr_valid),
  .mem_addr      (mem_addr),
  .mem_take      (mem_take),
  .refill_done   (refill_done),
  .stall_count   (stall_count)
);

// File: tb/test_blk_refill_ctrl.sv
module test_blk_refill_ctrl;
  localparam int HIT_LAT  = 2;
  localparam int MISS_LAT = 69;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_data;
  logic        rsp_hit;
  logic        mem_addr_valid;
  logic [15:0] mem_addr;
  logic        mem_take;
  logic [31:0] mem_rdata;
  logic        refill_done;
  logic [7:0]  stall_count;

  int total = 0;
  int bad = 0;
  int strobes = 0;

  bit        mv [16];
  bit [9:0]  mt [16];

  always #10 clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [15:0] a);
    return ({16'h0, a} * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  assign mem_rdata = mem_word(mem_addr);

  blk_refill_ctrl i_blk_refill_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_hit(rsp_hit),
    .mem_addr_valid(mem_addr_valid), .mem_addr(mem_addr), .mem_take(mem_take),
    .mem_rdata(mem_rdata), .refill_done(refill_done), .stall_count(stall_count)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Memory-side monitor, sampled on falling edges
  int        mon_gap = 0;
  int        mon_takes = 0;
  bit        mon_prev_done = 1'b0;
  bit [13:0] mon_blk = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_addr_valid) begin
        strobes++;
        mon_gap = 0;
        mon_takes = 0;
        mon_blk = mem_addr[15:2];
        check(mem_addr[1:0] == 2'd0, "R3", "strobe word offset", {30'd0, mem_addr[1:0]}, 0);
      end else begin
        mon_gap++;
      end
      if (mem_take) begin
        check(mon_gap == 16, "R4", "cycles before transfer", mon_gap, 16);
        check(mem_addr == {mon_blk, mon_takes[1:0]}, "R3", "transfer address",
              {16'd0, mem_addr}, {16'd0, mon_blk, mon_takes[1:0]});
        mon_takes++;
        mon_gap = 0;
      end
      if (refill_done) begin
        check(stall_count == 8'd65, "R5", "stall count at done", {24'd0, stall_count}, 65);
        check(mon_takes == 4, "R6", "transfers before done", mon_takes, 4);
        check(!mon_prev_done, "R6", "done pulse width", 1, 0);
      end
      mon_prev_done = refill_done;
    end
  end

  task automatic access(input logic [15:0] a, input int hold);
    bit [3:0]    idx  = a[5:2];
    bit [9:0]    tg   = a[15:6];
    bit          exp_hit = mv[idx] && (mt[idx] == tg);
    logic [31:0] exp_data = mem_word(a);
    int          lat;
    int          s0;
    logic [31:0] held;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    s0 = strobes;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = $urandom;
    check(!req_ready, "R9", "ready low while busy", {31'd0, req_ready}, 0);
    lat = 1;
    while (!rsp_valid && lat < 300) begin
      @(negedge clk);
      lat++;
    end
    if (exp_hit) begin
      check(lat == HIT_LAT, "R2", "hit latency", lat, HIT_LAT);
      check(strobes == s0, "R2", "memory strobes on hit", strobes - s0, 0);
    end else begin
      check(lat == MISS_LAT, "R5", "miss latency", lat, MISS_LAT);
      check(strobes == s0 + 1, "R7", "memory strobes on miss", strobes - s0, 1);
    end
    check(rsp_hit == exp_hit, exp_hit ? "R2" : "R8", "hit flag", {31'd0, rsp_hit}, {31'd0, exp_hit});
    check(rsp_data == exp_data, "R1", "returned word", rsp_data, exp_data);
    held = rsp_data;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check(rsp_valid && rsp_data == held, "R9", "response held under back-pressure", rsp_data, held);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(!rsp_valid && req_ready, "R9", "response released", {31'd0, rsp_valid}, 0);
    mv[idx] = 1'b1;
    mt[idx] = tg;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed_val;
    seed_val = $urandom(32'd2024);
    for (int i = 0; i < 16; i++) begin
      mv[i] = 1'b0;
      mt[i] = '0;
    end
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid && !mem_addr_valid && !mem_take && !refill_done
          && stall_count == 0, "R10", "outputs in reset", {31'd0, req_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid && stall_count == 0, "R10", "idle after reset",
          {24'd0, stall_count}, 0);

    // Directed: cold miss, spatial hits, conflict eviction, re-miss
    access(16'h0016, 0);             // R10: cold slot misses
    access(16'h0014, 2);             // R7: same line, other word hits
    access(16'h0017, 0);             // R7
    access(16'h0056, 3);             // R8: same slot, new tag
    access(16'h0016, 0);             // R8: old tag misses again
    access(16'h003F, 1);             // R1: last slot, last word
    access(16'hFFC0, 0);             // R1: top tag, slot 0

    // Random mix over three tags
    for (int n = 0; n < 60; n++) begin
      logic [15:0] a;
      a[15:6] = 10'($urandom_range(0, 2) * 10'h155);
      a[5:0]  = 6'($urandom);
      access(a, $urandom_range(0, 3));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule